// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Gating

This block collects interrupt requests from five sources of a small microcontroller and turns the most urgent one into a vector address for the core. The five sources are an external pin, two timer overflows, an analog-to-digital end-of-conversion and a two-wire serial bus event. Each source has a request flag and an enable bit. A master enable gates all five. The flags and enables live in two 8-bit control registers. The CPU reads and writes these registers over a simple select/write-strobe bus.

Requests are evaluated only on a machine-cycle phase pulse. Anything that arrives between two pulses is considered on the later one. A request is taken only when the master enable is on, its own enable is on, its flag is set, and the core's return-address stack is not full. Taking a request does four things. It emits a one-cycle acknowledge strobe, latches the vector address, clears the served flag and drops the master enable. A return-with-interrupt-enable strobe from the core turns the master enable back on. A plain return strobe leaves it alone.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00, `ack` is 0 and `vector` is 0x00.
- R2: Register 0 (`reg_sel`=0) has this layout: master enable at bit 0, enables for external, timer 0 and timer 1 at bits 1..3, and their flags at bits 4..6. Register 1 (`reg_sel`=1) holds the converter enable at bit 0, the serial-bus enable at bit 1, the converter flag at bit 4 and the serial-bus flag at bit 5. Unused bits read 0, so writing 0xFF reads back 0x7F from register 0 and 0x33 from register 1.
- R3: A high-to-low transition on `ext_pin` sets the external flag (register 0 bit 4); a low-to-high transition does not.
- R4: The `tmr0_evt` strobe sets register 0 bit 5. The `tmr1_evt` strobe sets register 0 bit 6. The `adc_evt` strobe sets register 1 bit 4. Either `bus_addr_evt` or `bus_byte_evt` sets register 1 bit 5.
- R5: A request is taken only at a clock edge where `phase` is 1. At that edge the master enable, the source enable and the flag must all be 1, and `stack_full` must be 0. `ack` is then high for exactly the following cycle, with `vector` equal to 0x04 (external), 0x08 (timer 0), 0x0C (timer 1), 0x10 (converter) or 0x14 (serial bus).
- R6: When several requests are eligible at once, the external source wins, then timer 0, timer 1, the converter and the serial bus, in that order.
- R7: Taking a request clears its flag and the master enable, and leaves every other flag and enable unchanged.
- R8: While `stack_full` is 1, no request is taken and pending flags stay set. The request is served at the first phase pulse after `stack_full` falls.
- R9: A `ret_irq` strobe sets the master enable. A `ret_plain` strobe does not change it.
- R10: If a peripheral event and a register write clearing the same flag occur in the same cycle, the flag ends up set.
- R11: A flag set by a register write, with its enables on, is served like a hardware-set flag.
- R12: `vector` keeps its value between acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 1 | Machine-cycle evaluation pulse |
| ext_pin | input | 1 | External interrupt pin, falling-edge active |
| tmr0_evt | input | 1 | Timer 0 overflow strobe |
| tmr1_evt | input | 1 | Timer 1 overflow strobe |
| adc_evt | input | 1 | Conversion-complete strobe |
| bus_addr_evt | input | 1 | Serial bus own-address match strobe |
| bus_byte_evt | input | 1 | Serial bus byte-complete strobe |
| stack_full | input | 1 | Return-address stack has no free entry |
| ret_irq | input | 1 | Return that re-enables interrupts |
| ret_plain | input | 1 | Ordinary return |
| reg_sel | input | 1 | Control register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| ack | output | 1 | Interrupt acknowledge strobe |
| vector | output | 8 | Vector address of the last taken request |

## Verification
Every piece of internal state shows up at the ports. A flag or enable that is wrong shows up in `reg_rdata` as soon as the register is read. A wrong choice of winner shows up as a wrong `vector` in the cycle after the phase edge. The bench's scoreboard compares that vector against its own priority model. A stuck master enable shows up as a missing acknowledge, or as an extra one that the scoreboard did not expect. A bad stack gate shows up as an acknowledge while `stack_full` is high, within one phase period.

// File: rtl/irq_pkg.sv
// Package: shared constants and field-mapping helpers for the interrupt controller.
// Assumes five sources indexed 0..4 in priority order (0 highest).
package irq_pkg;
    localparam int NSRC  = 5;
    localparam int DW    = 8;
    localparam int NLOW  = 3;   // sources living in register 0
    localparam int VSTEP = 4;   // spacing of vector addresses

    typedef enum logic [2:0] {
        SRC_EXT  = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_TMR1 = 3'd2,
        SRC_ADC  = 3'd3,
        SRC_BUS  = 3'd4
    } src_e;

    // Register that holds the fields of source i
    function automatic logic reg_of(input int i);
        return (i >= NLOW);
    endfunction

    // Bit position of the enable of source i within its register
    function automatic int en_pos(input int i);
        return (i < NLOW) ? i + 1 : i - NLOW;
    endfunction

    // Bit position of the flag of source i within its register
    function automatic int flag_pos(input int i);
        return (i < NLOW) ? i + 4 : i + 1;
    endfunction

    // Vector address for source index
    function automatic logic [DW-1:0] vec_of(input logic [2:0] idx);
        return DW'((int'(idx) + 1) * VSTEP);
    endfunction
endpackage

// File: rtl/irq_fall_det.sv
// Module: detects a high-to-low transition on a synchronous pin.
// Assumes the pin is already synchronous to clk; the pin idles high, so the
// history register resets to 1 and a pin held low through reset is no edge.
module irq_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic prev_q;

    // Remember the pin level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin;
    end

    assign fall = prev_q & ~pin;
endmodule

// File: rtl/irq_arbiter.sv
// Module: fixed-priority pick among eligible requests, lowest index wins.
// Assumes req already includes every gating term; purely combinational.
module irq_arbiter #(
    parameter int N  = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] seen;   // seen[i]: some request below index i is active

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
    assign any = seen[N];

    // Encode the one-hot grant into an index
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    // R6: never more than one winner
    always_comb begin
        p_grant_onehot_r6: assert ($onehot0(grant));
    end
endmodule

// File: rtl/irq_regfile.sv
// Module: the two control registers (master enable, source enables, flags).
// Priorities: flag = hardware set > acknowledge clear > software write;
// master enable = acknowledge clear > return-with-enable > software write.
module irq_regfile
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_evt,
    input  logic [NSRC-1:0] take,
    input  logic            ret_irq,
    input  logic            wr,
    input  logic            sel,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            gie,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] flag
);
    logic            gie_q;
    logic [NSRC-1:0] en_q, flag_q;
    logic            taken;
    logic            unused_wbits;

    assign taken        = |take;
    assign unused_wbits = ^wdata;

    // Master enable update
    always_ff @(posedge clk) begin
        if (!rst_n)              gie_q <= 1'b0;
        else if (taken)          gie_q <= 1'b0;
        else if (ret_irq)        gie_q <= 1'b1;
        else if (wr && !sel)     gie_q <= wdata[0];
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic R  = reg_of(i);
        localparam int   EP = en_pos(i);
        localparam int   FP = flag_pos(i);

        // Enable bit of source i, software only
        always_ff @(posedge clk) begin
            if (!rst_n)             en_q[i] <= 1'b0;
            else if (wr && sel == R) en_q[i] <= wdata[EP];
        end

        // Flag of source i with set-over-clear priority
        always_ff @(posedge clk) begin
            if (!rst_n)              flag_q[i] <= 1'b0;
            else if (set_evt[i])     flag_q[i] <= 1'b1;
            else if (take[i])        flag_q[i] <= 1'b0;
            else if (wr && sel == R) flag_q[i] <= wdata[FP];
        end

        // R10: an event always leaves the flag set
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flag_q[i]);
    end

    // Assemble the read view; unused bits stay 0
    always_comb begin
        rdata = '0;
        if (!sel) rdata[0] = gie_q;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == reg_of(i)) begin
                rdata[en_pos(i)]   = en_q[i];
                rdata[flag_pos(i)] = flag_q[i];
            end
        end
    end

    assign gie  = gie_q;
    assign en   = en_q;
    assign flag = flag_q;

    // R9: a return with enable, not overridden by an acknowledge, sets the enable
    p_ret_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_irq && !taken) |=> gie_q);
    // R7: an acknowledge drops the master enable
    p_take_clears_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !gie_q);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the vectored interrupt controller with stack gating.
// Assumes all inputs are synchronous to clk; events are one-cycle strobes.
// Evaluation happens only at edges where phase is high.
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase,
    input  logic          ext_pin,
    input  logic          tmr0_evt,
    input  logic          tmr1_evt,
    input  logic          adc_evt,
    input  logic          bus_addr_evt,
    input  logic          bus_byte_evt,
    input  logic          stack_full,
    input  logic          ret_irq,
    input  logic          ret_plain,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          ack,
    output logic [DW-1:0] vector
);
    localparam int IW = $clog2(NSRC);

    logic            ext_fall;
    logic [NSRC-1:0] set_evt, eligible, grant, take, en, flag;
    logic [IW-1:0]   win_idx;
    logic            win_any, gie;
    logic            ack_q;
    logic [DW-1:0]   vec_q;
    logic            unused_ret_plain;

    // A plain return has no effect on the controller
    assign unused_ret_plain = ret_plain;

    irq_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .fall  (ext_fall)
    );

    assign set_evt = {bus_addr_evt | bus_byte_evt, adc_evt, tmr1_evt, tmr0_evt, ext_fall};

    // Gate requests by phase, master enable and stack space
    assign eligible = {NSRC{phase & gie & ~stack_full}} & en & flag;

    irq_arbiter #(.N(NSRC)) u_arb (
        .req   (eligible),
        .grant (grant),
        .idx   (win_idx),
        .any   (win_any)
    );

    assign take = grant;

    irq_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .take    (take),
        .ret_irq (ret_irq),
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .gie     (gie),
        .en      (en),
        .flag    (flag)
    );

    // Acknowledge strobe and vector latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            vec_q <= '0;
        end else begin
            ack_q <= win_any;
            if (win_any) vec_q <= vec_of(3'(win_idx));
        end
    end

    assign ack    = ack_q;
    assign vector = vec_q;

    // R5: an acknowledge follows a phase edge
    p_ack_on_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(phase));
    // R8: never acknowledge when the stack had no room
    p_no_ack_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !$past(stack_full));
    // R12: vector only moves with an acknowledge
    p_vec_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> $stable(vector));
    // R5: the strobe lasts one cycle since the enable drops with it
    p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
// Bench: scoreboard of expected vectors, plus register read-back checks.
module sim_irq_vector_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase = 1'b0;
    logic       ext_pin = 1'b1;
    logic       tmr0_evt = 1'b0, tmr1_evt = 1'b0, adc_evt = 1'b0;
    logic       bus_addr_evt = 1'b0, bus_byte_evt = 1'b0;
    logic       stack_full = 1'b0, ret_irq = 1'b0, ret_plain = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ack;
    logic [7:0] vector;

    int checks = 0, errors = 0, ack_cnt = 0;
    bit done = 0, phase_auto = 0;
    logic [1:0] pcnt = '0;
    logic [7:0] expq[$];

    always #10 clk = ~clk;   // 50 MHz

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .phase(phase), .ext_pin(ext_pin),
        .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt), .adc_evt(adc_evt),
        .bus_addr_evt(bus_addr_evt), .bus_byte_evt(bus_byte_evt),
        .stack_full(stack_full), .ret_irq(ret_irq), .ret_plain(ret_plain),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack(ack), .vector(vector)
    );

    // Phase pulse: one cycle in four while enabled
    always @(negedge clk) begin
        pcnt  <= pcnt + 2'd1;
        phase <= phase_auto && (pcnt == 2'd3);
    end

    // Monitor: pop an expected vector on each acknowledge
    always @(negedge clk) begin
        if (rst_n && ack) begin
            ack_cnt++;
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R5/R6 unexpected ack vector=%h expected none", vector);
            end else begin
                automatic logic [7:0] e = expq.pop_front();
                if (vector !== e) begin
                    errors++;
                    $display("FAIL R6 vector=%h expected %h", vector, e);
                end
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string req);
        reg_sel = sel;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(0, 8'h00, "R1 reg0");
        rd(1, 8'h00, "R1 reg1");
        check("R1 ack", {7'd0, ack}, 8'h00);
        check("R1 vector", vector, 8'h00);

        // R2 layout and unused bits (phase held off)
        wr(0, 8'hFF); rd(0, 8'h7F, "R2 reg0");
        wr(0, 8'h00); rd(0, 8'h00, "R2 reg0 clear");
        wr(1, 8'hFF); rd(1, 8'h33, "R2 reg1");
        wr(1, 8'h00); rd(1, 8'h00, "R2 reg1 clear");

        // R3 falling edge sets flag, rising does not
        ext_pin = 1'b0; idle(2); rd(0, 8'h10, "R3 falling");
        wr(0, 8'h00);
        ext_pin = 1'b1; idle(2); rd(0, 8'h00, "R3 rising ignored");

        // R4 peripheral events
        strobe(tmr0_evt); strobe(tmr1_evt); strobe(adc_evt); strobe(bus_addr_evt);
        rd(0, 8'h60, "R4 timers");
        rd(1, 8'h30, "R4 adc and bus addr");
        wr(1, 8'h00);
        strobe(bus_byte_evt); rd(1, 8'h20, "R4 bus byte");
        wr(1, 8'h00); wr(0, 8'h00);

        // R5/R6/R7 all five pending, served in priority order
        wr(0, 8'h0E); wr(1, 8'h03);
        ext_pin = 1'b0; idle(1); ext_pin = 1'b1;
        strobe(tmr0_evt); strobe(tmr1_evt); strobe(adc_evt); strobe(bus_addr_evt);
        rd(0, 8'h7E, "R4 all flags");
        expq.push_back(8'h04);
        wr(0, 8'h7F);
        idle(6);
        check("R5 no ack without phase", 8'(ack_cnt), 8'd0);
        phase_auto = 1;
        idle(8); rd(0, 8'h6E, "R7 ext served");
        rd(1, 8'h33, "R7 reg1 untouched");
        expq.push_back(8'h08); wr(0, 8'h6F); idle(8); rd(0, 8'h4E, "R7 tmr0 served");
        expq.push_back(8'h0C); wr(0, 8'h4F); idle(8); rd(0, 8'h0E, "R7 tmr1 served");
        expq.push_back(8'h10); wr(0, 8'h0F); idle(8); rd(1, 8'h23, "R7 adc served");
        expq.push_back(8'h14); wr(0, 8'h0F); idle(8); rd(1, 8'h03, "R7 bus served");
        rd(0, 8'h0E, "R7 gie cleared");

        // R8 stack full holds the request
        stack_full = 1'b1;
        wr(0, 8'h05); strobe(tmr0_evt);
        idle(12);
        check("R8 no ack while full", 8'(ack_cnt), 8'd5);
        rd(0, 8'h25, "R8 pending kept");
        expq.push_back(8'h08);
        stack_full = 1'b0;
        idle(8);
        rd(0, 8'h04, "R8 served after release");

        // R9 return strobes
        strobe(ret_plain); rd(0, 8'h04, "R9 plain return");
        strobe(ret_irq);   rd(0, 8'h05, "R9 return with enable");

        // R10 event beats same-cycle software clear
        phase_auto = 0; idle(2);
        tmr0_evt = 1'b1; wr(0, 8'h00); tmr0_evt = 1'b0;
        rd(0, 8'h20, "R10 set wins");
        wr(0, 8'h00);

        // R11 software-set flag triggers
        wr(1, 8'h11); wr(0, 8'h01);
        expq.push_back(8'h10);
        phase_auto = 1;
        idle(10);
        rd(1, 8'h01, "R11 flag served");

        // R12 vector holds
        idle(10);
        check("R12 vector held", vector, 8'h10);
        check("R12 ack low", {7'd0, ack}, 8'h00);
        check("R5 total acks", 8'(ack_cnt), 8'd7);
        check("R6 queue drained", 8'(expq.size()), 8'd0);

        done = 1;
        finish_run();
    end
endmodule